// File: doc/BRIEF.md
# Stride-Order Transport Sample Demapper

This block sits behind the transport layer of a high-speed serial receive lane. It takes one received frame of octets per strobe and rebuilds the samples of the single stream that the lane carries, returned in natural order. The transmitter may place the samples of a frame in linear order or in stride order. In stride order, a first pass visits sample indices 0, SI, 2·SI and so on while the index is below S. Each later pass starts one index higher than the previous pass and steps by SI again, until all S samples have been placed.

The settings are static: the sample width code, the sample count S, the frame length F in octets, and the interleave factor SI. From S and SI the block derives the frame-slot-to-sample permutation combinationally. It registers the reordered samples one clock after the frame strobe. Samples are packed back to back from the most significant bit of the frame, so 12-bit samples cross octet boundaries. Settings that the permutation or the frame cannot hold raise a configuration error, and frames are then dropped.

Top module: `sample_demap`

## Requirements
- R1: With SI = 1, output sample j is taken from frame slot j, for every j below S.
- R2: With SI > 1, output sample j is taken from frame slot (j mod SI)·(S/SI) + floor(j/SI). This follows from passes that start at 0, 1, 2, … and step by SI while the index is below S.
- R3: Frame slot k occupies `frm_dat_i[FB-1-k·N -: N]`, where FB = 8·MAX_F. Bit FB-1 is the most significant bit of the first octet, and slots follow one another with no padding.
- R4: Width code `n_sel_i` = 0 selects 8-bit, 1 selects 12-bit and 2 selects 16-bit samples. Sample j appears right-aligned and zero-extended in `smp_dat_o[16·j +: 16]`.
- R5: Output sample positions j ≥ S read as zero.
- R6: `smp_vld_o` rises exactly one clock after each cycle where `frm_vld_i` is high and `cfg_err_o` is low. In every other case it is low.
- R7: `cfg_err_o` is high when SI is 0 or SI does not divide S. A frame received then produces no valid strobe and leaves the outputs unchanged.
- R8: `cfg_err_o` is also high when S is 0 or above MAX_S, when F is 0 or above MAX_F, when the width code is 3, or when S·N exceeds 8·F.
- R9: `smp_dat_o` changes only in the cycle after an accepted frame, and holds its value otherwise.
- R10: During reset `smp_vld_o` is 0 and `smp_dat_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frm_vld_i | input | 1 | Frame strobe, one cycle per frame |
| frm_dat_i | input | 8·MAX_F | Frame octets, first octet in the top bits |
| n_sel_i | input | 2 | Sample width code (0: 8, 1: 12, 2: 16) |
| s_cnt_i | input | $clog2(MAX_S+1) | Samples per frame S |
| f_cnt_i | input | $clog2(MAX_F+1) | Octets per frame F |
| si_i | input | $clog2(MAX_S+1) | Interleave factor SI |
| smp_vld_o | output | 1 | Samples valid strobe |
| smp_dat_o | output | 16·MAX_S | Samples in natural order, 16-bit field each |
| cfg_err_o | output | 1 | Settings unusable |

## Verification
The assertions assume that the width, count, length and interleave settings stay constant around each frame strobe. They also assume that a frame strobe lasts one cycle, so that each valid pulse can be traced to exactly one frame. The stimulus changes settings only at falling edges between frames and raises the frame strobe for a single cycle. It sweeps every S that fits with every SI among 1, 2, 4, 8 and 16 that divides S, for all three widths. It also drives each illegal setting on its own, next to a preceding good frame whose output must survive.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int unsigned SMP_W = 16;

  typedef enum logic [1:0] {
    W_8   = 2'd0,
    W_12  = 2'd1,
    W_16  = 2'd2,
    W_BAD = 2'd3
  } wsel_e;

  function automatic logic [4:0] wbits(logic [1:0] code);
    case (wsel_e'(code))
      W_8:     return 5'd8;
      W_12:    return 5'd12;
      W_16:    return 5'd16;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/sdm_cfg_chk.sv
module sdm_cfg_chk #(
  parameter int unsigned MAX_S = 16,
  parameter int unsigned MAX_F = 16,
  localparam int unsigned SW = $clog2(MAX_S + 1),
  localparam int unsigned FW = $clog2(MAX_F + 1)
) (
  input  logic [SW-1:0] s_cnt_i,
  input  logic [FW-1:0] f_cnt_i,
  input  logic [SW-1:0] si_i,
  input  logic [1:0]    n_sel_i,
  output logic          err_o
);
  localparam logic [SW-1:0] S_LIM = SW'(MAX_S);
  localparam logic [FW-1:0] F_LIM = FW'(MAX_F);

  logic          div_ok;
  logic [15:0]   need_bits;
  logic [15:0]   have_bits;

  // SI divides S iff some multiple m*SI, 1 <= m <= MAX_S, hits S
  always_comb begin
    logic [2*SW-1:0] acc;
    acc    = '0;
    div_ok = 1'b0;
    for (int i = 0; i < int'(MAX_S); i++) begin
      acc = acc + (2*SW)'(si_i);
      if (acc == (2*SW)'(s_cnt_i)) div_ok = 1'b1;
    end
  end

  assign need_bits = 16'(s_cnt_i) * 16'(sdm_pkg::wbits(n_sel_i));
  assign have_bits = 16'(f_cnt_i) << 3;

  assign err_o = (si_i == '0) || !div_ok
              || (s_cnt_i == '0) || (s_cnt_i > S_LIM)
              || (f_cnt_i == '0) || (f_cnt_i > F_LIM)
              || (n_sel_i == 2'd3)
              || (need_bits > have_bits);
endmodule

// File: rtl/sdm_perm.sv
module sdm_perm #(
  parameter int unsigned MAX_S = 16,
  localparam int unsigned SW = $clog2(MAX_S + 1),
  localparam int unsigned IW = (MAX_S > 1) ? $clog2(MAX_S) : 1
) (
  input  logic [SW-1:0]       s_cnt_i,
  input  logic [SW-1:0]       si_i,
  output logic [MAX_S*IW-1:0] slot_o
);
  // walk the stride passes: slot k carries sample cur
  always_comb begin
    logic [SW:0] cur;
    logic [SW:0] base;
    logic [SW:0] nxt;
    slot_o = '0;
    cur    = '0;
    base   = '0;
    nxt    = '0;
    for (int k = 0; k < int'(MAX_S); k++) begin
      if (((SW+1)'(k) < {1'b0, s_cnt_i}) && (cur < (SW+1)'(MAX_S)))
        slot_o[int'(cur)*IW +: IW] = IW'(k);
      nxt = cur + {1'b0, si_i};
      if (nxt >= {1'b0, s_cnt_i}) begin
        base = base + 1'b1;
        cur  = base;
      end else begin
        cur = nxt;
      end
    end
  end
endmodule

// File: rtl/sdm_slots.sv
module sdm_slots #(
  parameter int unsigned MAX_S = 16,
  parameter int unsigned FB    = 128,
  localparam int unsigned SMP_W = sdm_pkg::SMP_W
) (
  input  logic [FB-1:0]          frm_i,
  input  logic [1:0]             n_sel_i,
  output logic [MAX_S*SMP_W-1:0] fld_o
);
  for (genvar k = 0; k < int'(MAX_S); k++) begin : g_slot
    logic [7:0]       f8;
    logic [11:0]      f12;
    logic [15:0]      f16;
    logic [SMP_W-1:0] v;

    if ((k + 1) * 8 <= int'(FB)) begin : g_w8
      assign f8 = frm_i[int'(FB) - 1 - k*8 -: 8];
    end else begin : g_w8_none
      assign f8 = '0;
    end
    if ((k + 1) * 12 <= int'(FB)) begin : g_w12
      assign f12 = frm_i[int'(FB) - 1 - k*12 -: 12];
    end else begin : g_w12_none
      assign f12 = '0;
    end
    if ((k + 1) * 16 <= int'(FB)) begin : g_w16
      assign f16 = frm_i[int'(FB) - 1 - k*16 -: 16];
    end else begin : g_w16_none
      assign f16 = '0;
    end

    always_comb begin
      case (n_sel_i)
        2'd0:    v = SMP_W'(f8);
        2'd1:    v = SMP_W'(f12);
        default: v = SMP_W'(f16);
      endcase
    end
    assign fld_o[k*SMP_W +: SMP_W] = v;
  end
endmodule

// File: rtl/sample_demap.sv
module sample_demap #(
  parameter int unsigned MAX_S = 16,
  parameter int unsigned MAX_F = 16,
  localparam int unsigned FB    = 8 * MAX_F,
  localparam int unsigned SMP_W = sdm_pkg::SMP_W,
  localparam int unsigned SW    = $clog2(MAX_S + 1),
  localparam int unsigned FW    = $clog2(MAX_F + 1),
  localparam int unsigned IW    = (MAX_S > 1) ? $clog2(MAX_S) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frm_vld_i,
  input  logic [FB-1:0]          frm_dat_i,
  input  logic [1:0]             n_sel_i,
  input  logic [SW-1:0]          s_cnt_i,
  input  logic [FW-1:0]          f_cnt_i,
  input  logic [SW-1:0]          si_i,
  output logic                   smp_vld_o,
  output logic [MAX_S*SMP_W-1:0] smp_dat_o,
  output logic                   cfg_err_o
);
  logic                   err;
  logic [MAX_S*IW-1:0]    slot_map;
  logic [MAX_S*SMP_W-1:0] fld;
  logic [MAX_S*SMP_W-1:0] nat;
  logic                   take;

  sdm_cfg_chk #(.MAX_S(MAX_S), .MAX_F(MAX_F)) u_cfg (
    .s_cnt_i (s_cnt_i),
    .f_cnt_i (f_cnt_i),
    .si_i    (si_i),
    .n_sel_i (n_sel_i),
    .err_o   (err)
  );

  sdm_perm #(.MAX_S(MAX_S)) u_perm (
    .s_cnt_i (s_cnt_i),
    .si_i    (si_i),
    .slot_o  (slot_map)
  );

  sdm_slots #(.MAX_S(MAX_S), .FB(FB)) u_slots (
    .frm_i   (frm_dat_i),
    .n_sel_i (n_sel_i),
    .fld_o   (fld)
  );

  for (genvar j = 0; j < int'(MAX_S); j++) begin : g_nat
    logic [IW-1:0] sl;
    assign sl = slot_map[j*IW +: IW];
    assign nat[j*SMP_W +: SMP_W] = (SW'(j) < s_cnt_i) ? fld[int'(sl)*SMP_W +: SMP_W] : '0;
  end

  assign take      = frm_vld_i & ~err;
  assign cfg_err_o = err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_vld_o <= 1'b0;
      smp_dat_o <= '0;
    end else begin
      smp_vld_o <= take;
      if (take) smp_dat_o <= nat;
    end
  end
endmodule

// File: rtl/sdm_sva.sv
module sdm_sva #(
  parameter int unsigned MAX_S = 16,
  localparam int unsigned SW = $clog2(MAX_S + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   frm_vld_i,
  input logic [SW-1:0]          s_cnt_i,
  input logic [SW-1:0]          si_i,
  input logic                   smp_vld_o,
  input logic [MAX_S*16-1:0]    smp_dat_o,
  input logic                   cfg_err_o
);
  assert_vld_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i && !cfg_err_o |=> smp_vld_o);

  assert_no_spurious_vld_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> !smp_vld_o);

  assert_err_drops_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !smp_vld_o);

  assert_si_zero_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_i == '0) |-> cfg_err_o);

  assert_s_range_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s_cnt_i == '0) || (s_cnt_i > SW'(MAX_S))) |-> cfg_err_o);

  assert_hold_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frm_vld_i && !cfg_err_o) |=> $stable(smp_dat_o));
endmodule

bind sample_demap sdm_sva #(.MAX_S(MAX_S)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frm_vld_i (frm_vld_i),
  .s_cnt_i   (s_cnt_i),
  .si_i      (si_i),
  .smp_vld_o (smp_vld_o),
  .smp_dat_o (smp_dat_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/sim_sample_demap.sv
module sim_sample_demap;
  localparam int MAX_S = 16;
  localparam int MAX_F = 16;
  localparam int FB    = 8 * MAX_F;
  localparam int SW    = $clog2(MAX_S + 1);
  localparam int FW    = $clog2(MAX_F + 1);
  localparam int OW    = MAX_S * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frm_vld = 1'b0;
  logic [FB-1:0] frm_dat = '0;
  logic [1:0]    n_sel = 2'd0;
  logic [SW-1:0] s_cnt = SW'(1);
  logic [FW-1:0] f_cnt = FW'(1);
  logic [SW-1:0] si = SW'(1);
  logic          smp_vld;
  logic [OW-1:0] smp_dat;
  logic          cfg_err;

  int total = 0;
  int bad   = 0;
  logic [OW-1:0] last_good = '0;

  always #5 clk = ~clk;

  sample_demap #(.MAX_S(MAX_S), .MAX_F(MAX_F)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .frm_vld_i (frm_vld),
    .frm_dat_i (frm_dat),
    .n_sel_i   (n_sel),
    .s_cnt_i   (s_cnt),
    .f_cnt_i   (f_cnt),
    .si_i      (si),
    .smp_vld_o (smp_vld),
    .smp_dat_o (smp_dat),
    .cfg_err_o (cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int wbits(int code);
    return (code == 0) ? 8 : (code == 1) ? 12 : 16;
  endfunction

  // reference packer: slot k = pass*q + idx holds sample pass + idx*si
  task automatic run_frame(input int code, input int s, input int stp, input int f, input int seed);
    int w;
    int q;
    int val[MAX_S];
    logic [FB-1:0] frame;
    logic [OW-1:0] exp_v;
    string req;
    w = wbits(code);
    q = s / stp;
    frame = '0;
    exp_v = '0;
    for (int j = 0; j < MAX_S; j++) val[j] = (j * 29 + seed * 113 + 7) & ((1 << w) - 1);
    for (int k = 0; k < s; k++) begin
      int smp;
      smp = (k / q) + (k % q) * stp;
      for (int b = 0; b < w; b++) frame[FB - 1 - k*w - b] = 1'((val[smp] >> (w - 1 - b)) & 1);
    end
    for (int j = 0; j < s; j++) exp_v[j*16 +: 16] = 16'(val[j]); // R4, R5: rest stay zero
    req = (stp == 1) ? "R1 R3 R4 R5" : "R2 R3 R4 R5";
    @(negedge clk);
    n_sel = 2'(code); s_cnt = SW'(s); si = SW'(stp); f_cnt = FW'(f);
    frm_dat = frame; frm_vld = 1'b1;
    #1;
    chk(cfg_err == 1'b0, "R8 legal cfg", OW'(cfg_err), OW'(0));
    @(negedge clk);
    frm_vld = 1'b0;
    frm_dat = ~frame;
    chk(smp_vld == 1'b1, "R6 vld after frame", OW'(smp_vld), OW'(1));
    chk(smp_dat == exp_v, req, smp_dat, exp_v);
    @(negedge clk);
    chk(smp_vld == 1'b0, "R6 single pulse", OW'(smp_vld), OW'(0));
    chk(smp_dat == exp_v, "R9 hold", smp_dat, exp_v);
    last_good = exp_v;
  endtask

  task automatic run_bad(input int code, input int s, input int stp, input int f, input string req);
    @(negedge clk);
    n_sel = 2'(code); s_cnt = SW'(s); si = SW'(stp); f_cnt = FW'(f);
    frm_dat = {FB/8{8'h5a}}; frm_vld = 1'b1;
    #1;
    chk(cfg_err == 1'b1, req, OW'(cfg_err), OW'(1));
    @(negedge clk);
    frm_vld = 1'b0;
    chk(smp_vld == 1'b0, {req, " no vld"}, OW'(smp_vld), OW'(0));
    chk(smp_dat == last_good, {req, " data kept"}, smp_dat, last_good);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 0;
    repeat (3) @(negedge clk);
    chk(smp_vld == 1'b0, "R10 reset vld", OW'(smp_vld), OW'(0));
    chk(smp_dat == '0, "R10 reset data", smp_dat, '0);
    rst_n = 1'b1;

    // sweep widths, sample counts and interleave factors that fit the frame
    for (int code = 0; code < 3; code++) begin
      for (int s = 1; s <= MAX_S; s++) begin
        for (int e = 0; e < 5; e++) begin
          int stp;
          int need;
          int f;
          stp  = 1 << e;
          need = (s * wbits(code) + 7) / 8;
          if ((s % stp) == 0 && s * wbits(code) <= FB) begin
            f = (seed % 2 == 0) ? need : MAX_F;
            run_frame(code, s, stp, f, seed);
            seed++;
          end
        end
      end
    end

    run_frame(0, 16, 4, 16, 77);
    run_bad(0, 16, 3, 16, "R7 si not divisor");
    run_bad(0, 16, 0, 16, "R7 si zero");
    run_bad(1, 8, 16, 16, "R7 si above s");
    run_bad(0, 0, 1, 16, "R8 s zero");
    run_bad(0, 17, 1, 16, "R8 s above max");
    run_bad(0, 4, 1, 0, "R8 f zero");
    run_bad(0, 4, 1, 17, "R8 f above max");
    run_bad(3, 4, 1, 16, "R8 width code 3");
    run_bad(1, 16, 4, 16, "R8 s*n too big");
    run_bad(0, 16, 8, 15, "R8 frame short");
    run_frame(1, 8, 4, 12, 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule